// File: doc/BRIEF.md
# UART Host Register Port and Interrupt Combiner

This block sits between a byte-wide processor bus and the serial engines of a UART. A data strobe, qualified by three chip enables, a register-select line and a read/write line, is turned into one of four bus operations: load a transmit character, fetch the received character, load the line configuration, or fetch the status byte. The block holds the 8-bit configuration register and the receive holding register. It builds the status byte from receiver results, transmitter empty flags and two peripheral status inputs. It drives an active-low request-to-send and merges every interrupt cause into one active-low interrupt line.

The strobe and the peripheral inputs are asynchronous. They are synchronised into the system clock domain, and leading- and trailing-edge pulses are derived from the synchronised strobe. The transmitter and receiver are outside this block: the receiver presents a character together with its error flags and a one-cycle load pulse, and the transmitter reports its holding and shift empty flags and takes a one-cycle load pulse with the character.

Top module: `uart_host_port`

## Requirements
- R1: The block is selected only when `chipEnA` and `chipEnB` are high and `chipEnN` is low. A selected strobe with `regSel`=0 and `rdWr`=0 loads `txBus` into `txData` and pulses `thrLoad`; with `regSel`=0 and `rdWr`=1 it reads receive data; with `regSel`=1 and `rdWr`=0 it writes the configuration; with `regSel`=1 and `rdWr`=1 it reads status. A strobe while unselected changes nothing.
- R2: A configuration write with bit 7 low loads all eight bits into `lineCfg`. The bits are: 0 parity off, 1 even parity, 2 stop select, 3 length select low, 4 length select high, 5 interrupt enable, 6 break, 7 transmit request.
- R3: A configuration write with bit 7 high sets bit 7 and leaves bits 6..0 unchanged.
- R4: `rxBus` shows the status byte during a selected read with `regSel`=1, the receive holding register during a selected read with `regSel`=0, and zero at all other times. Status bits: 0 data available, 1 overrun, 2 parity error, 3 framing error, 4 external status, 5 peripheral status event, 6 shift empty, 7 holding empty.
- R5: A receiver load stores `rxData`, sets data available and drives `daN` low. It copies the framing flag, and it copies the parity flag only when parity off (bit 0) is clear.
- R6: A receiver load sets overrun when data available is still set, and clears overrun otherwise.
- R7: A data read clears data available at the leading edge of the strobe, so `daN` is already high while the strobe is still asserted.
- R8: Status bit 4 is high while `extStatN` is low. Status bit 5 sets on a falling edge of `perStatIn` and is cleared by a status read at its trailing edge, so it still reads as 1 during that read.
- R9: `intN` is low exactly when interrupt enable (bit 5) is set and at least one cause is pending: data available, holding-empty event, transmitter-done event, clear-to-send event, or status bit 5.
- R10: A holding-empty event is recorded when holding empty and transmit request become true together, which includes setting the request while the holding register is empty. It is cleared at the leading edge of a status read or a transmit write.
- R11: A transmitter-done event is recorded when holding empty and shift empty become true together. It is cleared like the holding-empty event.
- R12: A rising edge of `ctsIn` while both transmit registers are empty records a clear-to-send event, cleared at the leading edge of a status read. When a set and a clear coincide, the set wins.
- R13: `rtsN` goes low on a transmit write or while transmit request is set. It returns high only when both transmit registers are empty and transmit request is low.
- R14: While `rstN` is low, the configuration, the status flags, the interrupt causes and the receive holding register are cleared, so `intN`, `rtsN` and `daN` are high and break is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous clear, active low |
| chipEnA | input | 1 | Chip enable, active high |
| chipEnB | input | 1 | Chip enable, active high |
| chipEnN | input | 1 | Chip enable, active low |
| regSel | input | 1 | 0 data registers, 1 configuration/status |
| rdWr | input | 1 | 1 read, 0 write |
| strobe | input | 1 | Asynchronous bus data strobe, active high |
| txBus | input | 8 | Write data from the processor |
| rxBus | output | 8 | Read data to the processor |
| rxData | input | 8 | Character from the receiver |
| rxLoad | input | 1 | One-cycle receiver load pulse |
| rxParErr | input | 1 | Parity error of the loaded character |
| rxFrmErr | input | 1 | Framing error of the loaded character |
| txHoldEmpty | input | 1 | Transmitter holding register empty |
| txShiftEmpty | input | 1 | Transmitter shift register empty |
| txData | output | 8 | Character for the transmitter |
| thrLoad | output | 1 | One-cycle transmit load pulse |
| lineCfg | output | 8 | Configuration register |
| ctsIn | input | 1 | Clear-to-send from the peripheral |
| extStatN | input | 1 | External status level, active low |
| perStatIn | input | 1 | Peripheral status, falling edge is an event |
| rtsN | output | 1 | Request-to-send, active low |
| daN | output | 1 | Data available, active low |
| intN | output | 1 | Combined interrupt, active low |

## Verification
The bench builds the block with `SYNC_STAGES` = 3, which is one stage deeper than the default. Every bus operation therefore sees a longer delay from strobe to action. This shows that the leading- and trailing-edge timing of R7 and R8 depends on the derived pulses and not on a fixed delay. The chosen depth keeps the bus operation short enough to sample in the middle of the strobe, between the leading-edge and trailing-edge actions. That mid-strobe sample is where the difference between the data-available clear and the peripheral-status clear can be seen.

// File: rtl/uart_hp_pkg.sv
package uart_hp_pkg;
  localparam int REG_W = 8;

  // configuration bit positions
  localparam int CFG_PAR_OFF = 0;
  localparam int CFG_EVEN    = 1;
  localparam int CFG_STOP    = 2;
  localparam int CFG_LEN0    = 3;
  localparam int CFG_LEN1    = 4;
  localparam int CFG_IE      = 5;
  localparam int CFG_BREAK   = 6;
  localparam int CFG_TREQ    = 7;

  // status bit positions
  localparam int ST_DA    = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_EXT   = 4;
  localparam int ST_PEV   = 5;
  localparam int ST_SHE   = 6;
  localparam int ST_HOE   = 7;

  typedef struct packed {
    logic wrTx;
    logic rdRx;
    logic wrCfg;
    logic rdStLead;
    logic rdStTrail;
    logic pevFall;
    logic ctsRise;
  } hp_strobe_t;
endpackage

// File: rtl/uart_hp_ctrl.sv
module uart_hp_ctrl
  import uart_hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnA,
  input  logic       chipEnB,
  input  logic       chipEnN,
  input  logic       regSel,
  input  logic       rdWr,
  input  logic       strobe,
  input  logic       ctsIn,
  input  logic       extStatN,
  input  logic       perStatIn,
  output hp_strobe_t stb,
  output logic       busRead,
  output logic       extActive
);
  localparam int NSIG = 4;
  localparam int I_STB = 0;
  localparam int I_CTS = 1;
  localparam int I_PEV = 2;
  localparam int I_EXT = 3;
  // idle levels: strobe low, cts low, peripheral status high, ext status high
  localparam logic [NSIG-1:0] IDLE = 4'b1100;

  logic [NSIG-1:0] rawIn;
  logic [SYNC_STAGES-1:0][NSIG-1:0] syncPipe;
  logic [NSIG-1:0] syncNow;
  logic [NSIG-1:0] syncPrev;
  logic selected;
  logic leadPulse;
  logic trailPulse;

  assign rawIn = {extStatN, perStatIn, ctsIn, strobe};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= {SYNC_STAGES{IDLE}};
      syncPrev <= IDLE;
    end else begin
      syncPipe[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      syncPrev <= syncNow;
    end
  end

  assign syncNow    = syncPipe[SYNC_STAGES-1];
  assign selected   = chipEnA & chipEnB & ~chipEnN;
  assign leadPulse  = syncNow[I_STB] & ~syncPrev[I_STB];
  assign trailPulse = ~syncNow[I_STB] & syncPrev[I_STB];

  always_comb begin
    stb           = '0;
    stb.wrTx      = leadPulse & selected & ~regSel & ~rdWr;
    stb.rdRx      = leadPulse & selected & ~regSel &  rdWr;
    stb.wrCfg     = leadPulse & selected &  regSel & ~rdWr;
    stb.rdStLead  = leadPulse & selected &  regSel &  rdWr;
    stb.rdStTrail = trailPulse & selected & regSel &  rdWr;
    stb.pevFall   = ~syncNow[I_PEV] & syncPrev[I_PEV];
    stb.ctsRise   = syncNow[I_CTS] & ~syncPrev[I_CTS];
  end

  assign busRead   = selected & rdWr;
  assign extActive = ~syncNow[I_EXT];

  // R1
  bus_op_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrTx, stb.rdRx, stb.wrCfg, stb.rdStLead, stb.rdStTrail}));

  // R1
  no_op_unselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selected |-> !(stb.wrTx | stb.rdRx | stb.wrCfg | stb.rdStLead));
endmodule

// File: rtl/uart_hp_dpath.sv
module uart_hp_dpath
  import uart_hp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hp_strobe_t       stb,
  input  logic             busRead,
  input  logic             regSel,
  input  logic             extActive,
  input  logic [REG_W-1:0] txBus,
  input  logic [REG_W-1:0] rxData,
  input  logic             rxLoad,
  input  logic             rxParErr,
  input  logic             rxFrmErr,
  input  logic             txHoldEmpty,
  input  logic             txShiftEmpty,
  output logic [REG_W-1:0] lineCfg,
  output logic [REG_W-1:0] txData,
  output logic             thrLoad,
  output logic [REG_W-1:0] rxBus,
  output logic             daN,
  output logic             intN,
  output logic             rtsN
);
  logic [REG_W-1:0] cfgReg;
  logic [REG_W-1:0] rxHold;
  logic [REG_W-1:0] statusByte;
  logic dataAvail, overrun, parErr, frmErr, pevBit;
  logic holdIrq, doneIrq, ctsIrq;
  logic holdCond, holdCondQ, doneCond, doneCondQ;
  logic rtsActive;
  logic txClear;

  assign holdCond = txHoldEmpty & cfgReg[CFG_TREQ];
  assign doneCond = txHoldEmpty & txShiftEmpty;
  assign txClear  = stb.rdStLead | stb.wrTx;

  // configuration and transmit character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      txData <= '0;
    end else begin
      if (stb.wrCfg) begin
        if (txBus[CFG_TREQ]) cfgReg[CFG_TREQ] <= 1'b1;
        else                 cfgReg <= txBus;
      end
      if (stb.wrTx) txData <= txBus;
    end
  end

  // receive holding register and receive status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold    <= '0;
      dataAvail <= 1'b0;
      overrun   <= 1'b0;
      parErr    <= 1'b0;
      frmErr    <= 1'b0;
    end else if (rxLoad) begin
      rxHold    <= rxData;
      overrun   <= dataAvail;
      dataAvail <= 1'b1;
      parErr    <= rxParErr & ~cfgReg[CFG_PAR_OFF];
      frmErr    <= rxFrmErr;
    end else if (stb.rdRx) begin
      dataAvail <= 1'b0;
    end
  end

  // event flags: set has priority over the clearing strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pevBit    <= 1'b0;
      holdIrq   <= 1'b0;
      doneIrq   <= 1'b0;
      ctsIrq    <= 1'b0;
      holdCondQ <= 1'b0;
      doneCondQ <= 1'b1;
    end else begin
      holdCondQ <= holdCond;
      doneCondQ <= doneCond;
      if (stb.pevFall)                         pevBit <= 1'b1;
      else if (stb.rdStTrail)                  pevBit <= 1'b0;
      if (holdCond & ~holdCondQ)               holdIrq <= 1'b1;
      else if (txClear)                        holdIrq <= 1'b0;
      if (doneCond & ~doneCondQ)               doneIrq <= 1'b1;
      else if (txClear)                        doneIrq <= 1'b0;
      if (stb.ctsRise & doneCond)              ctsIrq <= 1'b1;
      else if (stb.rdStLead)                   ctsIrq <= 1'b0;
    end
  end

  // request-to-send
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 rtsActive <= 1'b0;
    else if (stb.wrTx | cfgReg[CFG_TREQ])      rtsActive <= 1'b1;
    else if (doneCond)                         rtsActive <= 1'b0;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[ST_DA]   = dataAvail;
    statusByte[ST_OVR]  = overrun;
    statusByte[ST_PAR]  = parErr;
    statusByte[ST_FRM]  = frmErr;
    statusByte[ST_EXT]  = extActive;
    statusByte[ST_PEV]  = pevBit;
    statusByte[ST_SHE]  = txShiftEmpty;
    statusByte[ST_HOE]  = txHoldEmpty;
  end

  assign rxBus   = busRead ? (regSel ? statusByte : rxHold) : '0;
  assign lineCfg = cfgReg;
  assign thrLoad = stb.wrTx;
  assign daN     = ~dataAvail;
  assign rtsN    = ~rtsActive;
  assign intN    = ~(cfgReg[CFG_IE] &
                     (dataAvail | holdIrq | doneIrq | ctsIrq | pevBit));

  // R3
  treq_keeps_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCfg && txBus[CFG_TREQ] |=>
      lineCfg[CFG_TREQ] && lineCfg[REG_W-2:0] == $past(lineCfg[REG_W-2:0]));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad && !daN |=> statusByte[ST_OVR]);

  // R7
  data_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRx && !rxLoad |=> daN);

  // R8
  pev_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pevFall |=> statusByte[ST_PEV]);

  // R12
  cts_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctsRise && txHoldEmpty && txShiftEmpty && lineCfg[CFG_IE] |=> !intN);

  // R13
  rts_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTx |=> !rtsN);
endmodule

// File: rtl/uart_host_port.sv
module uart_host_port
  import uart_hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEnA,
  input  logic             chipEnB,
  input  logic             chipEnN,
  input  logic             regSel,
  input  logic             rdWr,
  input  logic             strobe,
  input  logic [REG_W-1:0] txBus,
  output logic [REG_W-1:0] rxBus,
  input  logic [REG_W-1:0] rxData,
  input  logic             rxLoad,
  input  logic             rxParErr,
  input  logic             rxFrmErr,
  input  logic             txHoldEmpty,
  input  logic             txShiftEmpty,
  output logic [REG_W-1:0] txData,
  output logic             thrLoad,
  output logic [REG_W-1:0] lineCfg,
  input  logic             ctsIn,
  input  logic             extStatN,
  input  logic             perStatIn,
  output logic             rtsN,
  output logic             daN,
  output logic             intN
);
  hp_strobe_t stb;
  logic busRead;
  logic extActive;

  uart_hp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .chipEnA(chipEnA), .chipEnB(chipEnB), .chipEnN(chipEnN),
    .regSel(regSel), .rdWr(rdWr), .strobe(strobe),
    .ctsIn(ctsIn), .extStatN(extStatN), .perStatIn(perStatIn),
    .stb(stb), .busRead(busRead), .extActive(extActive)
  );

  uart_hp_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busRead(busRead), .regSel(regSel),
    .extActive(extActive), .txBus(txBus), .rxData(rxData), .rxLoad(rxLoad),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .txHoldEmpty(txHoldEmpty),
    .txShiftEmpty(txShiftEmpty), .lineCfg(lineCfg), .txData(txData),
    .thrLoad(thrLoad), .rxBus(rxBus), .daN(daN), .intN(intN), .rtsN(rtsN)
  );
endmodule

// File: tb/uart_host_port_tb.sv
module uart_host_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEnA = 1'b0, chipEnB = 1'b0, chipEnN = 1'b1;
  logic regSel = 1'b0, rdWr = 1'b0, strobe = 1'b0;
  logic [7:0] txBus = '0, rxData = '0;
  logic rxLoad = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0;
  logic holdE = 1'b1, shiftE = 1'b1;
  logic ctsIn = 1'b0, extStatN = 1'b1, perStatIn = 1'b1;
  logic [7:0] rxBus, txData, lineCfg;
  logic thrLoad, rtsN, daN, intN;

  int nTests = 0;
  int nFail = 0;

  // bench model of receive state
  logic mDa = 0, mOe = 0, mPe = 0, mFe = 0;
  logic [7:0] mHold = '0;
  logic [7:0] mCfg = '0;

  always #10 clk = ~clk;

  uart_host_port #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rstN(rstN), .chipEnA(chipEnA), .chipEnB(chipEnB),
    .chipEnN(chipEnN), .regSel(regSel), .rdWr(rdWr), .strobe(strobe),
    .txBus(txBus), .rxBus(rxBus), .rxData(rxData), .rxLoad(rxLoad),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .txHoldEmpty(holdE),
    .txShiftEmpty(shiftE), .txData(txData), .thrLoad(thrLoad),
    .lineCfg(lineCfg), .ctsIn(ctsIn), .extStatN(extStatN),
    .perStatIn(perStatIn), .rtsN(rtsN), .daN(daN), .intN(intN)
  );

  // transmitter model: a load fills the holding register
  always @(negedge clk) if (thrLoad) holdE = 1'b0;

  function automatic logic [7:0] expStatus(input logic pev, input logic ext);
    return {holdE, shiftE, pev, ext, mFe, mPe, mOe, mDa};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // en = {chipEnA, chipEnB, chipEnN}
  task automatic busOp(input logic rs, input logic rw, input logic [7:0] wd,
                       input logic [2:0] en, output logic [7:0] mid,
                       output logic midDaN);
    @(negedge clk);
    {chipEnA, chipEnB, chipEnN} = en;
    regSel = rs; rdWr = rw; txBus = wd; strobe = 1'b1;
    repeat (8) @(negedge clk);
    mid = rxBus; midDaN = daN;
    strobe = 1'b0;
    repeat (8) @(negedge clk);
    chipEnA = 1'b0; chipEnN = 1'b1; rdWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    logic [7:0] m; logic q;
    busOp(1'b1, 1'b0, d, 3'b110, m, q);
    if (d[7]) mCfg[7] = 1'b1; else mCfg = d;
  endtask

  task automatic txWrite(input logic [7:0] d);
    logic [7:0] m; logic q;
    busOp(1'b0, 1'b0, d, 3'b110, m, q);
  endtask

  task automatic statRead(output logic [7:0] mid);
    logic q;
    busOp(1'b1, 1'b1, 8'h00, 3'b110, mid, q);
  endtask

  task automatic dataRead(output logic [7:0] mid, output logic midDaN);
    busOp(1'b0, 1'b1, 8'h00, 3'b110, mid, midDaN);
    mDa = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk);
    rxData = d; rxParErr = p; rxFrmErr = f; rxLoad = 1'b1;
    @(negedge clk);
    rxLoad = 1'b0;
    mOe = mDa; mDa = 1'b1; mPe = p & ~mCfg[0]; mFe = f; mHold = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic q;
    void'($urandom(32'd2024));
    waitN(4);
    // R14 state while held in clear
    chk("R14 cfg in clear", lineCfg, 8'h00);
    chk("R14 outputs in clear", {5'b0, intN, rtsN, daN}, 8'h07);
    rstN = 1'b1;
    waitN(4);
    statRead(v);
    chk("R4 status after clear", v, 8'hC0);
    dataRead(v, q);
    chk("R4 holding after clear", v, 8'h00);
    chk("R4 bus idle", rxBus, 8'h00);

    // R2 / R3 configuration writes
    cfgWrite(8'h3A);
    chk("R2 full cfg load", lineCfg, 8'h3A);
    cfgWrite(8'h80);
    chk("R3 request only", lineCfg, 8'hBA);
    cfgWrite(8'h05);
    chk("R2 request cleared", lineCfg, 8'h05);
    waitN(4);

    // R1 unselected strobes
    busOp(1'b1, 1'b0, 8'h11, 3'b010, v, q);
    chk("R1 enable A low", lineCfg, 8'h05);
    busOp(1'b1, 1'b0, 8'h11, 3'b111, v, q);
    chk("R1 enable N high", lineCfg, 8'h05);
    busOp(1'b0, 1'b0, 8'h66, 3'b100, v, q);
    chk("R1 enable B low tx", txData, 8'h00);
    txWrite(8'h9C);
    chk("R1 tx data load", txData, 8'h9C);
    holdE = 1'b1;
    chk("R4 bus zero on read while unselected", rxBus, 8'h00);
    waitN(4);

    // R5 / R6 / R7 random receive traffic
    for (int it = 0; it < 40; it++) begin
      logic [7:0] d;
      cfgWrite(8'($urandom) & 8'h5F);
      d = 8'($urandom);
      rxPush(d, 1'($urandom), 1'($urandom));
      chk("R5 daN low after load", {7'b0, daN}, 8'h00);
      if ($urandom % 3 == 0) begin
        d = 8'($urandom);
        rxPush(d, 1'($urandom), 1'($urandom));
      end
      statRead(v);
      chk("R5 R6 status byte", v, expStatus(1'b0, 1'b0));
      dataRead(v, q);
      chk("R5 holding data", v, mHold);
      chk("R7 daN high mid strobe", {7'b0, q}, 8'h01);
    end

    // R6 overrun cleared by a clean load
    cfgWrite(8'h00);
    rxPush(8'h12, 1'b1, 1'b0);
    rxPush(8'h34, 1'b1, 1'b0);
    statRead(v);
    chk("R6 overrun set", v, expStatus(1'b0, 1'b0));
    dataRead(v, q);
    rxPush(8'h56, 1'b0, 1'b1);
    statRead(v);
    chk("R6 overrun cleared", v, expStatus(1'b0, 1'b0));
    dataRead(v, q);

    // R8 external status and peripheral event
    extStatN = 1'b0; waitN(8);
    statRead(v);
    chk("R8 ext status level", v, expStatus(1'b0, 1'b1));
    extStatN = 1'b1; waitN(8);
    perStatIn = 1'b0; waitN(8);
    statRead(v);
    chk("R8 event seen mid read", v, expStatus(1'b1, 1'b0));
    statRead(v);
    chk("R8 event cleared at trailing", v, expStatus(1'b0, 1'b0));
    perStatIn = 1'b1; waitN(8);

    // R9 - R13 interrupts and request-to-send
    cfgWrite(8'h20);
    chk("R9 no cause", {7'b0, intN}, 8'h01);
    cfgWrite(8'h80);
    chk("R10 hold event on request", {7'b0, intN}, 8'h00);
    chk("R13 rts with request", {7'b0, rtsN}, 8'h00);
    statRead(v);
    chk("R10 cleared by status read", {7'b0, intN}, 8'h01);
    txWrite(8'h55);
    chk("R13 rts after load", {7'b0, rtsN}, 8'h00);
    chk("R10 no event while full", {7'b0, intN}, 8'h01);
    @(negedge clk); holdE = 1'b1; shiftE = 1'b0; waitN(3);
    chk("R10 hold empty with request", {7'b0, intN}, 8'h00);
    statRead(v);
    chk("R10 cleared again", {7'b0, intN}, 8'h01);
    shiftE = 1'b1; waitN(3);
    chk("R11 done event", {7'b0, intN}, 8'h00);
    cfgWrite(8'h20);
    chk("R13 rts released", {7'b0, rtsN}, 8'h01);
    chk("R11 not cleared by cfg write", {7'b0, intN}, 8'h00);
    statRead(v);
    chk("R11 cleared by status read", {7'b0, intN}, 8'h01);

    // R10 gating: hold empty without request
    shiftE = 1'b0; waitN(2);
    holdE = 1'b0; waitN(3);
    chk("R13 rts stays high without request", {7'b0, rtsN}, 8'h01);
    holdE = 1'b1; waitN(3);
    chk("R10 no event without request", {7'b0, intN}, 8'h01);
    shiftE = 1'b1; waitN(3);
    chk("R11 done from shift", {7'b0, intN}, 8'h00);
    txWrite(8'hA1);
    chk("R11 cleared by tx write", {7'b0, intN}, 8'h01);
    chk("R13 rts held while full", {7'b0, rtsN}, 8'h00);
    holdE = 1'b1; waitN(3);
    chk("R13 rts released when empty", {7'b0, rtsN}, 8'h01);
    statRead(v);

    // R12 clear-to-send event
    ctsIn = 1'b1; waitN(8);
    chk("R12 cts event", {7'b0, intN}, 8'h00);
    statRead(v);
    chk("R12 cleared by status read", {7'b0, intN}, 8'h01);
    ctsIn = 1'b0; waitN(8);

    // R9 interrupt enable masking
    cfgWrite(8'h00);
    rxPush(8'h7E, 1'b0, 1'b0);
    chk("R9 masked", {7'b0, intN}, 8'h01);
    cfgWrite(8'h20);
    chk("R9 data available", {7'b0, intN}, 8'h00);
    dataRead(v, q);
    chk("R9 cleared by data read", {7'b0, intN}, 8'h01);

    // R14 clear in mid-run
    cfgWrite(8'h80);
    rxPush(8'hC3, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    waitN(3);
    chk("R14 cfg cleared", lineCfg, 8'h00);
    chk("R14 outputs", {5'b0, intN, rtsN, daN}, 8'h07);
    rstN = 1'b1; waitN(3);
    mDa = 0; mOe = 0; mPe = 0; mFe = 0; mCfg = '0;
    dataRead(v, q);
    chk("R14 holding cleared", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule